// File: doc/BRIEF.md
# E1 Backplane Frame Offset Aligner

This block times the receive-side backplane serial output of an E1 stream. A framing pulse marks a reference point on the backplane. Frame output, which is one serial data bit per bit period plus a parallel signaling nibble for the current timeslot, begins a programmable number of whole timeslots plus a few extra bit periods after that pulse. Each timeslot carries 8 bits. The frame has 32 timeslots on a plain bus and 128 timeslots on a multiplexed bus. Once started, the frame repeats on its own. A later framing pulse realigns it.

The block runs on a system clock. A clock-enable input marks the active edges of the backplane clock. When the backplane clock runs at twice the bit rate, each bit period has two active edges, and an edge-select input picks which of them updates the outputs. A direct-start input removes the programmed offset, so that output begins at the pulse itself. The byte and signaling for each timeslot come from an external source. The block presents a timeslot address to that source and samples the returned byte and nibble in the same cycle.

Top module: `e1_frame_aligner`

## Requirements
- R1: With direct start low, bit 0 of timeslot 0 starts D = ts_off*8 + bit_off bit periods after the bit period in which the pulse is sampled. The bit period of the pulse has position -D modulo the frame length, and the position advances by one per bit period. ts_cnt and bit_cnt show the timeslot and bit of the data currently on sdat.
- R2: With mux_mode low the frame has 32 timeslots (256 bit periods). Only ts_off[4:0] is used, so an offset of 32 or more wraps modulo 32.
- R3: With mux_mode high the frame has 128 timeslots (1024 bit periods) and the full 7-bit ts_off (0 to 127) applies.
- R4: Data leaves most significant bit first. At bit_cnt = b, sdat equals bit 7-b of the source byte for timeslot ts_cnt.
- R5: ssig always equals the source signaling nibble of the timeslot shown on ts_cnt, so it stays aligned with sdat for any offset.
- R6: With dbl_clk high, each bit period spans two active edges, and the pulse edge is the first of them. With edge_sel = 0 the outputs change on the first edge of a bit period. With edge_sel = 1 they change on the second edge, one active edge later.
- R7: With dbl_clk low, edge_sel has no effect and the outputs change on every active edge.
- R8: With direct_start high, both offsets are ignored and bit 0 of timeslot 0 is output in the bit period of the pulse.
- R9: After the last bit of the last timeslot, output continues with timeslot 0 bit 0 without a new pulse.
- R10: A pulse that arrives while a frame is running reloads the position to -D (modulo the frame length) using the offsets in force at that pulse.
- R11: Reset clears all counters. sdat, ssig, ts_cnt and bit_cnt stay 0 until the first frame start after reset.
- R12: In a cycle with bclk_en low, no output changes and the pulse is not sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_en | input | 1 | Marks an active backplane clock edge |
| fpulse | input | 1 | Framing pulse, sampled on active edges |
| ts_off | input | 7 | Timeslot offset |
| bit_off | input | 3 | Extra bit-period offset |
| edge_sel | input | 1 | 0: first edge updates, 1: second edge updates (double-rate clock only) |
| dbl_clk | input | 1 | Backplane clock runs at twice the bit rate |
| mux_mode | input | 1 | 128-timeslot multiplexed frame |
| direct_start | input | 1 | Ignore offsets and start at the pulse |
| src_ts | output | 7 | Timeslot address presented to the data source |
| src_byte | input | 8 | Source byte for src_ts |
| src_sig | input | 4 | Source signaling nibble for src_ts |
| sdat | output | 1 | Serial data |
| ssig | output | 4 | Signaling for the current timeslot |
| ts_cnt | output | 7 | Timeslot currently output |
| bit_cnt | output | 3 | Bit currently output |

## Verification
The properties assume that dbl_clk, mux_mode, edge_sel and direct_start change only while reset is asserted, and that a framing pulse is held for exactly one active edge. The wrap and pulse-load properties also assume that ts_off and bit_off are steady around a pulse. The directed tasks meet these assumptions by setting all mode bits during a reset sequence. They change the offsets only between pulses and drive a one-cycle pulse together with bclk_en. In the test with a gapped clock enable, the pulse falls only on an enabled edge.

// File: rtl/e1_frame_aligner.sv
module e1_frame_aligner #(
  parameter int TS_W     = 7,
  parameter int NMX_TS_W = 5,
  parameter int BIT_W    = 3,
  parameter int SIG_W    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bclk_en,
  input  logic                      fpulse,
  input  logic [TS_W-1:0]           ts_off,
  input  logic [BIT_W-1:0]          bit_off,
  input  logic                      edge_sel,
  input  logic                      dbl_clk,
  input  logic                      mux_mode,
  input  logic                      direct_start,
  output logic [TS_W-1:0]           src_ts,
  input  logic [(1<<BIT_W)-1:0]     src_byte,
  input  logic [SIG_W-1:0]          src_sig,
  output logic                      sdat,
  output logic [SIG_W-1:0]          ssig,
  output logic [TS_W-1:0]           ts_cnt,
  output logic [BIT_W-1:0]          bit_cnt
);
  localparam int POS_W = TS_W + BIT_W;
  localparam logic [POS_W-1:0] NMX_MASK = POS_W'((1 << (NMX_TS_W + BIT_W)) - 1);
  localparam logic [TS_W-1:0]  NMX_TS_MASK = TS_W'((1 << NMX_TS_W) - 1);

  logic             sec, run;
  logic [POS_W-1:0] pos;

  wire [POS_W-1:0] fmask  = mux_mode ? '1 : NMX_MASK;
  wire [TS_W-1:0]  ts_eff = mux_mode ? ts_off : (ts_off & NMX_TS_MASK);
  wire [POS_W-1:0] dly    = direct_start ? '0 : {ts_eff, bit_off};

  wire tick = bclk_en && (!dbl_clk || !sec || fpulse);
  wire upd  = (dbl_clk && edge_sel) ? (bclk_en && !tick) : tick;

  wire [POS_W-1:0] pos_n   = (fpulse ? (POS_W'(0) - dly) : (pos + POS_W'(1))) & fmask;
  wire             run_n   = run || (pos_n == '0);
  wire [POS_W-1:0] sel_pos = tick ? pos_n : pos;
  wire             sel_run = tick ? run_n : run;

  assign src_ts = sel_pos[POS_W-1:BIT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec <= 1'b0;
      run <= 1'b0;
      pos <= '0;
    end else if (bclk_en) begin
      sec <= dbl_clk && tick;
      if (tick) begin
        pos <= pos_n;
        run <= run_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdat    <= 1'b0;
      ssig    <= '0;
      ts_cnt  <= '0;
      bit_cnt <= '0;
    end else if (upd) begin
      sdat    <= sel_run && src_byte[~sel_pos[BIT_W-1:0]];
      ssig    <= sel_run ? src_sig : '0;
      ts_cnt  <= sel_run ? src_ts : '0;
      bit_cnt <= sel_run ? sel_pos[BIT_W-1:0] : '0;
    end
  end
endmodule

// File: rtl/e1_frame_aligner_chk.sv
module e1_frame_aligner_chk #(
  parameter int TS_W  = 7,
  parameter int BIT_W = 3,
  parameter int SIG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bclk_en,
  input logic             fpulse,
  input logic [TS_W-1:0]  ts_off,
  input logic [BIT_W-1:0] bit_off,
  input logic             edge_sel,
  input logic             dbl_clk,
  input logic             mux_mode,
  input logic             direct_start,
  input logic             run,
  input logic             sdat,
  input logic [SIG_W-1:0] ssig,
  input logic [TS_W-1:0]  ts_cnt,
  input logic [BIT_W-1:0] bit_cnt
);
  // R12
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bclk_en |=> $stable(sdat) && $stable(ssig) && $stable(ts_cnt) && $stable(bit_cnt));

  // R2
  plain_ts_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mux_mode |-> ts_cnt < TS_W'(32));

  // R8
  direct_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbl_clk && bclk_en && fpulse && direct_start) |=> ts_cnt == '0 && bit_cnt == '0);

  // R1
  zero_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbl_clk && bclk_en && fpulse && ts_off == '0 && bit_off == '0) |=> ts_cnt == '0 && bit_cnt == '0);

  // R9
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbl_clk && bclk_en && !fpulse && run && bit_cnt == '1 &&
     ts_cnt == (mux_mode ? TS_W'(127) : TS_W'(31))) |=> ts_cnt == '0 && bit_cnt == '0);

  // R6
  late_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbl_clk && edge_sel && bclk_en && fpulse) |=> $stable(ts_cnt) && $stable(bit_cnt) && $stable(sdat));
endmodule

bind e1_frame_aligner e1_frame_aligner_chk #(.TS_W(TS_W), .BIT_W(BIT_W), .SIG_W(SIG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .fpulse(fpulse), .ts_off(ts_off),
  .bit_off(bit_off), .edge_sel(edge_sel), .dbl_clk(dbl_clk), .mux_mode(mux_mode),
  .direct_start(direct_start), .run(run), .sdat(sdat), .ssig(ssig),
  .ts_cnt(ts_cnt), .bit_cnt(bit_cnt)
);

// File: tb/e1_frame_aligner_bench.sv
module e1_frame_aligner_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bclk_en = 1'b0, fpulse = 1'b0;
  logic [6:0] ts_off = '0;
  logic [2:0] bit_off = '0;
  logic       edge_sel = 1'b0, dbl_clk = 1'b0, mux_mode = 1'b0, direct_start = 1'b0;
  logic [6:0] src_ts;
  logic [7:0] src_byte;
  logic [3:0] src_sig;
  logic       sdat;
  logic [3:0] ssig;
  logic [6:0] ts_cnt;
  logic [2:0] bit_cnt;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] sb(input int t);
    return 8'((t * 37 + 5) & 255);
  endfunction
  function automatic logic [3:0] ss(input int t);
    return 4'((t & 15) ^ 10);
  endfunction

  assign src_byte = sb(int'(src_ts));
  assign src_sig  = ss(int'(src_ts));

  e1_frame_aligner u_e1_frame_aligner (
    .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .fpulse(fpulse), .ts_off(ts_off),
    .bit_off(bit_off), .edge_sel(edge_sel), .dbl_clk(dbl_clk), .mux_mode(mux_mode),
    .direct_start(direct_start), .src_ts(src_ts), .src_byte(src_byte), .src_sig(src_sig),
    .sdat(sdat), .ssig(ssig), .ts_cnt(ts_cnt), .bit_cnt(bit_cnt)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input bit dbl, input bit es, input bit mux, input bit direct);
    @(negedge clk);
    rst_n = 1'b0; bclk_en = 1'b0; fpulse = 1'b0;
    dbl_clk = dbl; edge_sel = es; mux_mode = mux; direct_start = direct;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse();
    bclk_en = 1'b1; fpulse = 1'b1;
    @(negedge clk);
    fpulse = 1'b0;
  endtask

  // compares the outputs after each cycle with the frame position implied by the offset
  task automatic observe(input int d, input int f, input int n, input bit started,
                         input bit gap, input string req);
    int e = 0;
    for (int m = 0; m < n; m++) begin
      int bp, rel, p, ets, eb, ed, es4;
      bit skip, en_nx;
      skip = 1'b0;
      if (dbl_clk && edge_sel) begin
        skip = (e == 0);
        bp = (e - 1) / 2;
      end else if (dbl_clk) bp = e / 2;
      else bp = e;
      if (!skip) begin
        rel = bp - d;
        if (!started && rel < 0) begin
          ets = 0; eb = 0; ed = 0; es4 = 0;
        end else begin
          p = ((rel % f) + f) % f;
          ets = p / 8; eb = p % 8;
          ed = int'(sb(ets)[7 - eb]);
          es4 = int'(ss(ets));
        end
        chk(req, "ts_cnt", int'(ts_cnt), ets);
        chk(req, "bit_cnt", int'(bit_cnt), eb);
        chk("R4", "sdat", int'(sdat), ed);
        chk("R5", "ssig", int'(ssig), es4);
      end
      en_nx = gap ? !bclk_en : 1'b1;
      bclk_en = en_nx;
      @(negedge clk);
      if (en_nx) e++;
    end
  endtask

  task automatic t_reset(); // R11
    do_reset(0, 0, 0, 0);
    for (int i = 0; i < 20; i++) begin
      bclk_en = i[0];
      @(negedge clk);
      chk("R11", "sdat", int'(sdat), 0);
      chk("R11", "ts_cnt", int'(ts_cnt), 0);
      chk("R11", "ssig", int'(ssig), 0);
    end
  endtask

  task automatic t_basic(); // R1 R9 R11: D=29, runs past a frame wrap
    do_reset(0, 0, 0, 0);
    ts_off = 7'd3; bit_off = 3'd5;
    pulse();
    observe(29, 256, 330, 0, 0, "R1");
  endtask

  task automatic t_plain_wrap(); // R2: offset 40 wraps to 8
    do_reset(0, 0, 0, 0);
    ts_off = 7'd40; bit_off = 3'd2;
    pulse();
    observe(66, 256, 90, 0, 0, "R2");
  endtask

  task automatic t_mux(); // R3 R9
    do_reset(0, 0, 1, 0);
    ts_off = 7'd100; bit_off = 3'd3;
    pulse();
    observe(803, 1024, 1900, 0, 0, "R3");
  endtask

  task automatic t_dbl(input bit es); // R6
    do_reset(1, es, 0, 0);
    ts_off = 7'd2; bit_off = 3'd1;
    pulse();
    observe(17, 256, 120, 0, 0, "R6");
  endtask

  task automatic t_es_ignored(); // R7
    do_reset(0, 1, 0, 0);
    ts_off = 7'd1; bit_off = 3'd0;
    pulse();
    observe(8, 256, 60, 0, 0, "R7");
  endtask

  task automatic t_direct(); // R8
    do_reset(0, 0, 0, 1);
    ts_off = 7'd9; bit_off = 3'd4;
    pulse();
    observe(0, 256, 60, 0, 0, "R8");
  endtask

  task automatic t_gap(); // R12
    do_reset(0, 0, 0, 0);
    ts_off = 7'd1; bit_off = 3'd2;
    pulse();
    observe(10, 256, 100, 0, 1, "R12");
  endtask

  task automatic t_resync(); // R10
    do_reset(0, 0, 0, 0);
    ts_off = 7'd2; bit_off = 3'd4;
    pulse();
    observe(20, 256, 60, 0, 0, "R10");
    ts_off = 7'd5; bit_off = 3'd6;
    pulse();
    observe(46, 256, 120, 1, 0, "R10");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_basic();
        t_plain_wrap();
        t_mux();
        t_dbl(0);
        t_dbl(1);
        t_es_ignored();
        t_direct();
        t_gap();
        t_resync();
      end
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL R1 watchdog actual=running expected=finished");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule